// File: doc/BRIEF.md
# Remappable Address Decoder with Target Removal

This block turns a bus address into a one-hot target select. It covers six on-chip targets: the control block, the on-chip RAM, a second RAM, an interrupt controller, a trace unit and a spare region. A seventh select line stands for the external bus port. Each on-chip target owns an address window that is a power of two in size and aligned to that size. An address that lands in no enabled window goes to the external port. The select is registered, so it appears one cycle after the request strobe.

An 8-bit configuration register lives inside the control block's window. Each disable bit in it removes one target from the map. The space of a removed target then falls through to the external port. A separate remap bit makes the on-chip RAM also answer at address zero, and this alias ignores the RAM's own disable bit. If software disables the control block, the configuration register leaves the map with it. Further writes are then lost, and only a reset brings the register back.

Top module: `addr_map_decoder`

## Requirements
- R1: After reset the configuration register reads RST_CFG with bit 5 forced to 0. Bits [31:8] of the read data are 0.
- R2: A write to address CTRL_BASE+REG_OFS stores wdata[7:0] while the control block is enabled. Bits [31:8] are discarded and always read as zero.
- R3: Select encoding is bit0 control block, bit1 on-chip RAM, bit2 second RAM, bit3 interrupt controller, bit4 trace unit, bit5 spare region, bit6 external port. An address inside an enabled target's window raises that target's bit one cycle after the request.
- R4: The disable bits map as bit1 spare, bit2 second RAM, bit3 interrupt controller, bit4 control block, bit6 trace unit, bit7 on-chip RAM. When a target's disable bit is 1, addresses in its window select the external port.
- R5: An address that matches no window selects the external port.
- R6: With all disable bits set, every address outside the remap alias selects the external port.
- R7: When config bit 0 is 1, addresses below RAM_SPAN select the on-chip RAM, whatever config bit 7 holds. When bit 0 is 0, those addresses decode normally.
- R8: While config bit 4 is 1, register writes are ignored and register reads return 0, until the next reset.
- R9: tgt_valid follows req_valid by one cycle. tgt_sel has exactly one bit set when tgt_valid is 1 and is all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_valid | input | 1 | Address strobe |
| req_addr | input | 32 | Address to decode |
| tgt_valid | output | 1 | Registered strobe for the select |
| tgt_sel | output | 7 | One-hot target select |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 32 | Register access address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
The hardest state to reach is the lockout. Once the control block disables itself, the stimulus can no longer touch the register, so the sequence runs last. It writes the self-disable, tries to write again, and reads back. It then probes the control window, which must now go to the external port, and finally applies a reset to recover. The remap-versus-RAM-disable corner comes from a reset value with both bits 0 and 7 set. This shows the alias answering at zero while the RAM's own window already falls through.

// File: rtl/addr_map_decoder.sv
module addr_map_decoder #(
  parameter logic [31:0] CTRL_BASE = 32'h3F20_0000,
  parameter logic [31:0] CTRL_SPAN = 32'h0010_0000,
  parameter logic [31:0] REG_OFS   = 32'h0000_00E0,
  parameter logic [31:0] RAM_BASE  = 32'h3F80_0000,
  parameter logic [31:0] RAM_SPAN  = 32'h0010_0000,
  parameter logic [31:0] RAM2_BASE = 32'h3F40_0000,
  parameter logic [31:0] RAM2_SPAN = 32'h0010_0000,
  parameter logic [31:0] IRQ_BASE  = 32'h3F10_0000,
  parameter logic [31:0] IRQ_SPAN  = 32'h0000_1000,
  parameter logic [31:0] TRC_BASE  = 32'h3F00_0000,
  parameter logic [31:0] TRC_SPAN  = 32'h0000_1000,
  parameter logic [31:0] SPR_BASE  = 32'h3F30_0000,
  parameter logic [31:0] SPR_SPAN  = 32'h0001_0000,
  parameter logic [7:0]  RST_CFG   = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        tgt_valid,
  output logic [6:0]  tgt_sel,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata
);
  localparam int unsigned NWIN = 6;
  localparam int unsigned EXT  = NWIN;
  localparam logic [31:0] WIN_BASE [0:NWIN-1] =
    '{CTRL_BASE, RAM_BASE, RAM2_BASE, IRQ_BASE, TRC_BASE, SPR_BASE};
  localparam logic [31:0] WIN_SPAN [0:NWIN-1] =
    '{CTRL_SPAN, RAM_SPAN, RAM2_SPAN, IRQ_SPAN, TRC_SPAN, SPR_SPAN};
  localparam int unsigned DIS_BIT [0:NWIN-1] = '{4, 7, 2, 3, 6, 1};
  localparam logic [31:0] REG_ADDR = CTRL_BASE + REG_OFS;
  localparam logic [7:0]  CFG_INIT = RST_CFG & 8'hDF;

  logic [7:0]      cfg_q;
  logic [NWIN-1:0] hit;
  logic            alias_hit, ctrl_live, reg_hit;
  logic [6:0]      sel_d;

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_win
      assign hit[g] = ((req_addr & ~(WIN_SPAN[g] - 32'd1)) == WIN_BASE[g])
                      && !cfg_q[DIS_BIT[g]];
    end
  endgenerate

  assign alias_hit = cfg_q[0] && (req_addr < RAM_SPAN);
  assign ctrl_live = !cfg_q[4];
  assign reg_hit   = (cfg_addr == REG_ADDR);
  assign cfg_rdata = (reg_hit && ctrl_live) ? {24'd0, cfg_q} : 32'd0;

  always_comb begin
    sel_d = '0;
    if (alias_hit) begin
      sel_d[1] = 1'b1;
    end else begin
      for (int i = NWIN - 1; i >= 0; i--)
        if (hit[i]) sel_d = 7'(1) << i;
      if (hit == '0) sel_d[EXT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_INIT;
      tgt_valid <= 1'b0;
      tgt_sel   <= '0;
    end else begin
      if (cfg_wr && reg_hit && ctrl_live) cfg_q <= cfg_wdata[7:0];
      tgt_valid <= req_valid;
      tgt_sel   <= req_valid ? sel_d : '0;
    end
  end
endmodule

module addr_map_decoder_chk #(
  parameter logic [31:0] RAM_SPAN = 32'h0010_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        tgt_valid,
  input logic [6:0]  tgt_sel,
  input logic [7:0]  cfg_q,
  input logic [31:0] cfg_rdata
);
  assert_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> tgt_valid);
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!tgt_valid && tgt_sel == 7'd0));
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> $countones(tgt_sel) == 1);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:8] == 24'd0);
  assert_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[4] |=> $stable(cfg_q));
  assert_alias_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_q[0] && req_addr < RAM_SPAN) |=> tgt_sel[1]);
  assert_ctrl_gone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_q[4]) |=> !tgt_sel[0]);
endmodule

bind addr_map_decoder addr_map_decoder_chk #(.RAM_SPAN(RAM_SPAN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .tgt_valid(tgt_valid), .tgt_sel(tgt_sel), .cfg_q(cfg_q), .cfg_rdata(cfg_rdata)
);

// File: tb/addr_map_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_map_decoder_tb_top;
  localparam logic [31:0] REG_A = 32'h3F20_00E0;
  localparam logic [7:0]  RSTV  = 8'hA1;
  localparam logic [7:0]  RSTE  = 8'h81;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, cfg_wr = 1'b0;
  logic [31:0] req_addr = '0, cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic tgt_valid;
  logic [6:0] tgt_sel;
  int n_run = 0, n_fail = 0;
  logic [7:0] m_cfg;
  logic [6:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  addr_map_decoder #(.RST_CFG(RSTV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .tgt_valid(tgt_valid), .tgt_sel(tgt_sel), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  function automatic logic [6:0] model(input logic [31:0] a, input logic [7:0] c);
    if (c[0] && a < 32'h0010_0000)         return 7'h02;
    if (a[31:20] == 12'h3F2 && !c[4])      return 7'h01;
    if (a[31:20] == 12'h3F8 && !c[7])      return 7'h02;
    if (a[31:20] == 12'h3F4 && !c[2])      return 7'h04;
    if (a[31:12] == 20'h3F100 && !c[3])    return 7'h08;
    if (a[31:12] == 20'h3F000 && !c[6])    return 7'h10;
    if (a[31:16] == 16'h3F30 && !c[1])     return 7'h20;
    return 7'h40;
  endfunction

  task automatic send(input logic [31:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back(model(a, m_cfg)); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && tgt_valid) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected select: actual %h expected none", tgt_sel);
      end else begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (tgt_sel !== e) begin
          n_fail++;
          $display("FAIL %s select: actual %h expected %h", t, tgt_sel, e);
        end
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = REG_A; cfg_wdata = d;
    if (!m_cfg[4]) m_cfg = d[7:0];
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] e, input string tag);
    @(negedge clk);
    cfg_addr = REG_A; #1;
    n_run++;
    if (cfg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read: actual %h expected %h", tag, cfg_rdata, e);
    end
  endtask

  task automatic idle_chk();
    @(negedge clk); #1;
    n_run++;
    if (tgt_valid !== 1'b0 || tgt_sel !== 7'd0) begin
      n_fail++;
      $display("FAIL R9 idle: actual %b/%h expected 0/00", tgt_valid, tgt_sel);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; m_cfg = RSTE;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    m_cfg = RSTE;
    do_reset();
    rd({24'd0, RSTE}, "R1");
    idle_chk();
    send(32'h0000_0040, "R7 alias with RAM disabled");
    send(32'h3F80_0100, "R4 RAM window disabled");
    wr(32'hFFFF_FF00);
    rd(32'd0, "R2 upper bits dropped");
    send(32'h3F20_0010, "R3 control");
    send(32'h3F80_0100, "R3 RAM");
    send(32'h3F40_0040, "R3 second RAM");
    send(32'h3F10_0008, "R3 irq");
    send(32'h3F00_0FF0, "R3 trace");
    send(32'h3F30_1234, "R3 spare");
    send(32'h2000_0000, "R5 unmapped");
    send(32'h3F10_1000, "R5 past irq window");
    send(32'h0000_0040, "R7 no remap");
    idle_chk();
    wr(32'h0000_0020);
    rd(32'h0000_0020, "R2 bit5 stored");
    wr(32'h0000_0001);
    send(32'h000F_FFFF, "R7 last alias");
    send(32'h0010_0000, "R7 past alias");
    wr(32'h0000_00CE);
    send(32'h3F40_0040, "R4 second RAM off");
    send(32'h3F10_0008, "R4 irq off");
    send(32'h3F00_0FF0, "R4 trace off");
    send(32'h3F30_1234, "R4 spare off");
    send(32'h3F80_0100, "R4 RAM off");
    send(32'h3F20_0010, "R3 control still on");
    wr(32'h0000_00FE);
    send(32'h3F20_0010, "R6 control");
    send(32'h3F80_0000, "R6 RAM");
    send(32'h0000_0000, "R6 zero");
    do_reset();
    wr(32'h0000_00FF);
    send(32'h0000_0010, "R6 alias kept");
    send(32'h3F40_0000, "R6 second RAM");
    rd(32'd0, "R8 locked read");
    wr(32'h0000_0000);
    send(32'h3F20_0010, "R8 write ignored");
    do_reset();
    rd({24'd0, RSTE}, "R8 reset recovers");
    send(32'h3F20_0010, "R8 control back");
    idle_chk();
    repeat (3) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 missing selects: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule